// File: doc/BRIEF.md
# Stepped AGC Gain Controller

This block decides the gain that the audio signal path should apply, in half-decibel units. A two-bit strap picks one of four base gains. An attenuation ladder of `STEPS` positions then pulls the gain below that base, half a decibel per position. The ladder moves toward more attenuation while a peak comparator reports that the output has crossed its programmed limit. It moves back toward the base gain once the limit clears. Attack is fast and release is slow: each direction has its own count of time-base ticks per ladder position.

The time base is a single-cycle strobe, `tick_i`. Attack advances one position every `ATK_TICKS` ticks during which the limit is exceeded. Release retreats one position every `REL_TICKS` ticks during which the limit is clear. The ladder stops at both ends. Changing the strap, or asserting the disable flag, returns the ladder to position 0 and restarts both timers. The multiplier that applies the gain and the analog derivation of the limit live outside this block. All pins are plain control and status levels, with no streaming handshake.

The gain code is `2*base_dB - idx`. The real gain in dB is `gain_code/2 + 0.15`, so position 0 corresponds to the base plus 0.15 dB and position 31 to the base minus 15.35 dB.

Top module: `agc_gain_ctrl`

## Requirements
- R1: While `rst_n` is low, `att_idx_o` is 0 and `gain_code_o` is 40, which is the base for strap 00.
- R2: The strap `gain_sel_i` maps to these base codes in half-dB units: 00 to 40, 01 to 52, 10 to 64, 11 to 72. `gain_code_o` equals the base of the strap registered at the last edge minus `att_idx_o`.
- R3: While `over_limit_i` is high, `att_idx_o` rises by one on every `ATK_TICKS`-th tick-qualified cycle, counted since the limit was first seen high.
- R4: While `over_limit_i` is low, `att_idx_o` falls by one on every `REL_TICKS`-th tick-qualified cycle, counted since the limit was last seen high.
- R5: `att_idx_o` never exceeds `STEPS-1` and never goes below 0. Further attack at the top, or further release at 0, leaves it unchanged.
- R6: In the cycle after any change of `gain_sel_i`, `att_idx_o` is 0 and both step timers restart from zero.
- R7: While `agc_off_i` is high, `att_idx_o` is 0 and the timers are held at zero.
- R8: A cycle with `over_limit_i` low clears the attack count. A cycle with it high clears the release count.
- R9: Cycles with `tick_i` low neither advance the timers nor move the ladder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Time-base strobe, one cycle wide |
| gain_sel_i | input | 2 | Base-gain strap |
| over_limit_i | input | 1 | Peak comparator: output above limit |
| agc_off_i | input | 1 | Disable limiting, hold the base gain |
| gain_code_o | output | 7 | Current gain in half-dB units |
| att_idx_o | output | 5 | Ladder position, 0 = no attenuation |

## Verification
The bench builds the block with `STEPS=32`, `ATK_TICKS=3` and `REL_TICKS=7`. With these values a full descent of the ladder takes about a hundred cycles and a full ascent a few hundred, so both saturation ends are reached many times within a short run. The small counts also let timer restarts caused by brief limit glitches, missing ticks and strap changes land at every phase of both counters during the random phase. The full-scale timing defaults would put the release end out of reach in a short run.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int GAIN_W = 7;
  typedef logic [GAIN_W-1:0] gain_t;

  function automatic gain_t base_code(input logic [1:0] sel);
    case (sel)
      2'b00:   base_code = gain_t'(40);
      2'b01:   base_code = gain_t'(52);
      2'b10:   base_code = gain_t'(64);
      default: base_code = gain_t'(72);
    endcase
  endfunction
endpackage

// File: rtl/agc_base_decode.sv
module agc_base_decode
  import agc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  output logic       chg_o,
  output gain_t      base_o
);
  logic [1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= 2'b00;
    else        sel_q <= sel_i;
  end

  assign chg_o  = (sel_i != sel_q);
  assign base_o = base_code(sel_q);

  p_base_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (base_o == gain_t'(40) || base_o == gain_t'(52) ||
     base_o == gain_t'(64) || base_o == gain_t'(72)));
endmodule

// File: rtl/agc_step_timer.sv
module agc_step_timer #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic en_i,
  input  logic clr_i,
  output logic fire_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  logic [CW-1:0] cnt_q;
  logic          adv;

  assign adv    = en_i && tick_i && !clr_i;
  assign fire_o = adv && (cnt_q == CW'(N - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) cnt_q <= '0;
    else if (adv)        cnt_q <= fire_o ? '0 : cnt_q + 1'b1;
  end

  p_fire_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> (tick_i && en_i));
  p_clear_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/agc_ladder.sv
module agc_ladder #(
  parameter int STEPS = 32,
  localparam int IW = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          zero_i,
  input  logic          up_i,
  input  logic          dn_i,
  output logic [IW-1:0] idx_o
);
  localparam logic [IW-1:0] TOP = IW'(STEPS - 1);
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n || zero_i)          idx_q <= '0;
    else if (up_i && idx_q != TOP) idx_q <= idx_q + 1'b1;
    else if (dn_i && idx_q != '0)  idx_q <= idx_q - 1'b1;
  end

  assign idx_o = idx_q;

  p_zero_on_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    zero_i |=> (idx_q == '0));
  p_unit_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_i |=> (idx_q == $past(idx_q) || idx_q == $past(idx_q) + 1'b1 ||
                 idx_q + 1'b1 == $past(idx_q)));
  p_top_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == TOP && !dn_i && !zero_i) |=> (idx_q == TOP));
  p_bot_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == '0 && !up_i) |=> (idx_q == '0));
endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl
  import agc_pkg::*;
#(
  parameter int STEPS     = 32,
  parameter int ATK_TICKS = 1,
  parameter int REL_TICKS = 430,
  localparam int IW = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [1:0]        gain_sel_i,
  input  logic              over_limit_i,
  input  logic              agc_off_i,
  output logic [GAIN_W-1:0] gain_code_o,
  output logic [IW-1:0]     att_idx_o
);
  logic  sel_chg, atk_fire, rel_fire, flush;
  gain_t base;

  agc_base_decode u_dec (
    .clk(clk), .rst_n(rst_n), .sel_i(gain_sel_i), .chg_o(sel_chg), .base_o(base)
  );

  assign flush = agc_off_i || sel_chg;

  agc_step_timer #(.N(ATK_TICKS)) u_atk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .en_i(over_limit_i && !agc_off_i),
    .clr_i(!over_limit_i || flush), .fire_o(atk_fire)
  );

  agc_step_timer #(.N(REL_TICKS)) u_rel (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .en_i(!over_limit_i && !agc_off_i),
    .clr_i(over_limit_i || flush), .fire_o(rel_fire)
  );

  agc_ladder #(.STEPS(STEPS)) u_lad (
    .clk(clk), .rst_n(rst_n), .zero_i(flush),
    .up_i(atk_fire), .dn_i(rel_fire), .idx_o(att_idx_o)
  );

  assign gain_code_o = base - GAIN_W'(att_idx_o);

  p_off_forces_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    agc_off_i |=> (att_idx_o == '0));
  p_idle_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !flush) |=> $stable(att_idx_o));
  p_one_direction_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(atk_fire && rel_fire));
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (!rst_n -> (att_idx_o == '0 && gain_code_o == GAIN_W'(40))));
endmodule

// File: tb/agc_gain_ctrl_tb.sv
module agc_gain_ctrl_tb;
  localparam int STEPS = 32;
  localparam int ATK = 3;
  localparam int REL = 7;

  logic clk = 0;
  logic rst_n = 0;
  logic tick = 0;
  logic [1:0] gsel = 0;
  logic ov = 0;
  logic off = 0;
  logic [6:0] gain;
  logic [4:0] idx;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;
  int m_idx = 0, m_sel = 0, m_ac = 0, m_rc = 0;

  always #4 clk = ~clk;

  agc_gain_ctrl #(.STEPS(STEPS), .ATK_TICKS(ATK), .REL_TICKS(REL)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .gain_sel_i(gsel),
    .over_limit_i(ov), .agc_off_i(off), .gain_code_o(gain), .att_idx_o(idx)
  );

  function automatic int base_of(input int s);
    case (s)
      0: return 40;
      1: return 52;
      2: return 64;
      default: return 72;
    endcase
  endfunction

  function automatic void model_edge();
    bit chg = (int'(gsel) != m_sel);
    m_sel = int'(gsel);
    if (off || chg) begin
      m_idx = 0; m_ac = 0; m_rc = 0;
    end else if (ov) begin
      m_rc = 0;
      if (tick) begin
        if (m_ac == ATK-1) begin m_ac = 0; if (m_idx < STEPS-1) m_idx++; end
        else m_ac++;
      end
    end else begin
      m_ac = 0;
      if (tick) begin
        if (m_rc == REL-1) begin m_rc = 0; if (m_idx > 0) m_idx--; end
        else m_rc++;
      end
    end
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(req, int'(idx), m_idx);
    chk(req, int'(gain), base_of(m_sel) - m_idx);
  endtask

  task automatic drive(input int s, input bit o, input bit t, input bit d);
    gsel = 2'(s); ov = o; tick = t; off = d;
  endtask

  initial begin
    while (!done && cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=done", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk("R1 reset idx", int'(idx), 0);
    chk("R1 reset gain", int'(gain), 40);
    rst_n = 1;
    // R2: each strap value
    for (int s = 0; s < 4; s++) begin
      drive(s, 0, 0, 0);
      step("R2 decode");
      chk("R2 base literal", int'(gain), (s == 0) ? 40 : (s == 1) ? 52 : (s == 2) ? 64 : 72);
    end
    // R3: attack one step after ATK ticks
    drive(0, 1, 1, 0);
    step("R6 sel back");
    for (int i = 0; i < ATK; i++) step("R3 attack");
    chk("R3 after ATK ticks", int'(idx), 1);
    // R9: no tick, no motion
    drive(0, 1, 0, 0);
    for (int i = 0; i < 10; i++) step("R9 idle");
    chk("R9 held", int'(idx), 1);
    // R5: saturate at top
    drive(0, 1, 1, 0);
    for (int i = 0; i < 120; i++) step("R5 top");
    chk("R5 top literal", int'(idx), STEPS-1);
    chk("R5 top gain", int'(gain), 40 - (STEPS-1));
    // R4: release one step after REL ticks
    drive(0, 0, 1, 0);
    for (int i = 0; i < REL; i++) step("R4 release");
    chk("R4 after REL ticks", int'(idx), STEPS-2);
    // R8: glitch of limit restarts release count
    for (int i = 0; i < REL-1; i++) step("R8 partial");
    drive(0, 1, 0, 0);
    step("R8 glitch");
    drive(0, 0, 1, 0);
    for (int i = 0; i < REL-1; i++) step("R8 restart");
    chk("R8 no early release", int'(idx), STEPS-2);
    step("R8 release");
    chk("R8 release after full count", int'(idx), STEPS-3);
    // R5: saturate at bottom
    for (int i = 0; i < 300; i++) step("R5 bottom");
    chk("R5 bottom literal", int'(idx), 0);
    // R6: strap change clears ladder
    drive(1, 1, 1, 0);
    for (int i = 0; i < 20; i++) step("R6 ramp");
    drive(3, 1, 1, 0);
    step("R6 change");
    chk("R6 idx cleared", int'(idx), 0);
    chk("R6 new base", int'(gain), 72);
    // R7: disable holds base
    drive(3, 1, 1, 1);
    for (int i = 0; i < 30; i++) step("R7 off");
    chk("R7 idx zero", int'(idx), 0);
    // random phase
    begin
      bit o = 0;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(0, 15) == 0) o = ~o;
        drive(($urandom_range(0, 199) == 0) ? int'($urandom_range(0, 3)) : int'(gsel),
              o ^ ($urandom_range(0, 31) == 0),
              $urandom_range(0, 3) != 0,
              $urandom_range(0, 299) == 0);
        step("R3 R4 R5 R6 R7 R8 R9 random");
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule